// File: doc/BRIEF.md
# Dual-Clock Serial Port Data Buffer with Threshold Flags

This block holds the data that passes between a processor register interface and a serial shifter. It contains two independent 16-byte buffers. The transmit buffer is loaded by processor writes and emptied by the transmit shifter. The receive buffer is loaded by the receive shifter and emptied by processor reads. The processor side runs on `cpu_clk` and the shifter side runs on `ser_clk`. The two clocks are unrelated. Each side keeps its own read and write pointers. Each pointer is sent to the other clock domain as a Gray code through a two-stage synchroniser.

A mode input sets how both buffers are organised: sixteen single-byte entries, or four 32-bit words. The transmit free space is compared against a programmable threshold. That comparison drives a space flag and a transmit DMA request. The receive fill level is compared against a second threshold, which drives a data-ready flag and a receive DMA request. A transfer-complete flag reports that the transmit buffer has run dry and the shifter has finished its last frame. A sticky error flag reports a received frame that arrived while the receive buffer was full. Each direction has its own clear input. A clear empties that buffer, and it should be used only while the line is idle. The mode should be changed only after both buffers have been cleared.

Top module: `serport_buf`

## Requirements
- R1: After reset both buffers are empty. `tx_valid`, `rx_ready_irq` (with `rx_thr` above 0), `tx_done_irq` and `rx_err_irq` are 0, and `cpu_rdata` is 0.
- R2: With `wide_mode`=0, each buffer holds 16 single-byte entries. Only bits [7:0] are stored. The transmit shifter sees the entries oldest first on `tx_data[7:0]`, with bits [31:8] at 0. `cpu_rdata` returns received bytes in arrival order in bits [7:0], with bits [31:8] at 0.
- R3: With `wide_mode`=1, each buffer holds four 32-bit entries. All 32 bits are kept, and entries leave in the order they arrived.
- R4: A processor write to a full transmit buffer is discarded. It does not overwrite any stored entry.
- R5: `tx_space_irq` and `tx_dma_req` are both 1 exactly when the free entries in the transmit buffer are at least `tx_thr`. Entries are counted in bytes in byte mode and in words in word mode.
- R6: `rx_ready_irq` and `rx_dma_req` are both 1 exactly when the number of stored receive entries is at least `rx_thr`, counted in the same unit as R5.
- R7: `tx_done_irq` becomes 1 only after a `tx_frame_done` pulse that arrives while the transmit buffer is empty. It returns to 0 once the transmit buffer holds data again, or after a transmit clear.
- R8: An `rx_push` while the receive buffer is full discards that frame and sets `rx_err_irq`. The stored entries are left intact. `rx_err_irq` stays at 1 until a receive clear.
- R9: A processor read of an empty receive buffer leaves `cpu_rdata` at the last value read and does not move the read pointer. A `tx_pop` while `tx_valid` is 0 has no effect.
- R10: `tx_clr` and `rx_clr`, each held for at least three `ser_clk` periods, empty only their own buffer. The other buffer keeps its contents.
- R11: Every pointer sent across clock domains changes at most one bit per clock, except in the cycle after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor-side clock |
| cpu_rst_n | input | 1 | Processor-side asynchronous reset, active low |
| ser_clk | input | 1 | Shifter-side clock |
| ser_rst_n | input | 1 | Shifter-side asynchronous reset, active low |
| wide_mode | input | 1 | 0: sixteen byte entries; 1: four 32-bit entries |
| tx_thr | input | 5 | Transmit free-space threshold, in entries |
| rx_thr | input | 5 | Receive fill threshold, in entries |
| tx_clr | input | 1 | Empties the transmit buffer (processor domain, level) |
| rx_clr | input | 1 | Empties the receive buffer (processor domain, level) |
| cpu_wr | input | 1 | Processor write strobe to the transmit buffer |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rd | input | 1 | Processor read strobe from the receive buffer |
| cpu_rdata | output | 32 | Last entry read from the receive buffer |
| tx_pop | input | 1 | Shifter takes the oldest transmit entry |
| tx_valid | output | 1 | Transmit buffer holds an entry for the shifter |
| tx_data | output | 32 | Oldest transmit entry |
| tx_frame_done | input | 1 | Shifter pulse: last frame and stop bits finished |
| rx_push | input | 1 | Shifter delivers a complete received frame |
| rx_data | input | 32 | Received frame data |
| tx_space_irq | output | 1 | Transmit free space at or above threshold |
| tx_dma_req | output | 1 | Transmit DMA request, same condition |
| rx_ready_irq | output | 1 | Receive fill at or above threshold |
| rx_dma_req | output | 1 | Receive DMA request, same condition |
| tx_done_irq | output | 1 | Transfer complete |
| rx_err_irq | output | 1 | Receive overflow, sticky |

## Verification
The in-line properties check these on every cycle: the one-bit Gray step of each crossing pointer, the fact that pointers stay put on a rejected write or an empty read, the hold of `cpu_rdata` on an empty read, the set and stickiness of the overflow flag, and the clearing of transfer-complete once data is present. Only the directed scenarios can show the following: the data order in both organisations, the exact threshold crossing points in bytes and in words, the discarding of a seventeenth byte, the independence of the two clears, and the end-to-end latency through the synchronisers.

// File: rtl/serport_pkg.sv
`timescale 1ns/1ps
package serport_pkg;
  parameter int SP_BYTES      = 16;
  parameter int SP_WORD_BYTES = 4;
  localparam int SP_WORDS = SP_BYTES / SP_WORD_BYTES;
  localparam int SP_AW    = $clog2(SP_BYTES);
  localparam int SP_PW    = SP_AW + 1;
  localparam int SP_WSH   = $clog2(SP_WORD_BYTES);
  localparam int SP_DW    = 8 * SP_WORD_BYTES;

  typedef logic [SP_PW-1:0] ptr_t;
  typedef logic [SP_AW-1:0] addr_t;

  // wrap mask: pointer counts modulo twice the entry depth
  function automatic ptr_t f_mask(input logic wide);
    return wide ? ptr_t'(2*SP_WORDS-1) : ptr_t'(2*SP_BYTES-1);
  endfunction

  function automatic ptr_t f_depth(input logic wide);
    return wide ? ptr_t'(SP_WORDS) : ptr_t'(SP_BYTES);
  endfunction

  function automatic ptr_t f_next(input ptr_t p, input logic wide);
    return (p + ptr_t'(1)) & f_mask(wide);
  endfunction

  function automatic ptr_t f_fill(input ptr_t w, input ptr_t r, input logic wide);
    return (w - r) & f_mask(wide);
  endfunction

  function automatic ptr_t f_free(input ptr_t w, input ptr_t r, input logic wide);
    return f_depth(wide) - f_fill(w, r, wide);
  endfunction

  function automatic ptr_t f_bin2gray(input ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t f_gray2bin(input ptr_t g);
    ptr_t b;
    b[SP_PW-1] = g[SP_PW-1];
    for (int i = SP_PW-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // first byte slot of the entry a pointer selects
  function automatic addr_t f_byte_addr(input ptr_t p, input logic wide);
    return wide ? addr_t'(p << SP_WSH) : addr_t'(p);
  endfunction
endpackage

// File: rtl/serport_sync.sv
`timescale 1ns/1ps
module serport_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/serport_dir.sv
`timescale 1ns/1ps
module serport_dir
  import serport_pkg::*;
(
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             wclr,
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             rclr,
  input  logic             wide,
  input  logic             we,
  input  logic [SP_DW-1:0] wdata,
  output ptr_t             wfree,
  input  logic             re,
  output logic [SP_DW-1:0] rdata,
  output ptr_t             rfill
);
  logic [7:0] mem [SP_BYTES];

  ptr_t wptr, wptr_nxt, wgray_q, wgray_r, wptr_r;
  ptr_t rptr, rptr_nxt, rgray_q, rgray_w, rptr_w;
  addr_t waddr, raddr;
  logic w_accept, r_accept;

  // ---------------- write domain ----------------
  assign wfree    = f_free(wptr, rptr_w, wide);
  assign w_accept = we && (wfree != '0);
  assign wptr_nxt = wclr ? '0 : (w_accept ? f_next(wptr, wide) : wptr);
  assign waddr    = f_byte_addr(wptr, wide);

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wptr    <= '0;
      wgray_q <= '0;
    end else begin
      wptr    <= wptr_nxt;
      wgray_q <= f_bin2gray(wptr_nxt);
    end
  end

  always_ff @(posedge wclk) begin
    if (w_accept && !wclr) begin
      for (int b = 0; b < SP_WORD_BYTES; b++) begin
        if (wide || b == 0) mem[waddr + addr_t'(b)] <= wdata[8*b +: 8];
      end
    end
  end

  serport_sync #(.W(SP_PW)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray_q), .q(rgray_w)
  );
  assign rptr_w = f_gray2bin(rgray_w);

  // ---------------- read domain ----------------
  assign rfill    = f_fill(wptr_r, rptr, wide);
  assign r_accept = re && (rfill != '0);
  assign rptr_nxt = rclr ? '0 : (r_accept ? f_next(rptr, wide) : rptr);
  assign raddr    = f_byte_addr(rptr, wide);

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rptr    <= '0;
      rgray_q <= '0;
    end else begin
      rptr    <= rptr_nxt;
      rgray_q <= f_bin2gray(rptr_nxt);
    end
  end

  always_comb begin
    for (int b = 0; b < SP_WORD_BYTES; b++) begin
      rdata[8*b +: 8] = (wide || b == 0) ? mem[raddr + addr_t'(b)] : 8'h00;
    end
  end

  serport_sync #(.W(SP_PW)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray_q), .q(wgray_r)
  );
  assign wptr_r = f_gray2bin(wgray_r);

  // ---------------- assertions ----------------
  a_r11_wgray_step: assert property (@(posedge wclk) disable iff (!wrst_n)
    !$past(wclr) |-> $countones(wgray_q ^ $past(wgray_q)) <= 1);

  a_r11_rgray_step: assert property (@(posedge rclk) disable iff (!rrst_n)
    !$past(rclr) |-> $countones(rgray_q ^ $past(rgray_q)) <= 1);

  a_r4_full_write_holds: assert property (@(posedge wclk) disable iff (!wrst_n || wclr)
    (we && wfree == '0) |=> $stable(wptr));

  a_r9_empty_read_holds: assert property (@(posedge rclk) disable iff (!rrst_n || rclr)
    (re && rfill == '0) |=> $stable(rptr));
endmodule

// File: rtl/serport_buf.sv
`timescale 1ns/1ps
module serport_buf
  import serport_pkg::*;
(
  input  logic             cpu_clk,
  input  logic             cpu_rst_n,
  input  logic             ser_clk,
  input  logic             ser_rst_n,
  input  logic             wide_mode,
  input  logic [SP_PW-1:0] tx_thr,
  input  logic [SP_PW-1:0] rx_thr,
  input  logic             tx_clr,
  input  logic             rx_clr,
  input  logic             cpu_wr,
  input  logic [SP_DW-1:0] cpu_wdata,
  input  logic             cpu_rd,
  output logic [SP_DW-1:0] cpu_rdata,
  input  logic             tx_pop,
  output logic             tx_valid,
  output logic [SP_DW-1:0] tx_data,
  input  logic             tx_frame_done,
  input  logic             rx_push,
  input  logic [SP_DW-1:0] rx_data,
  output logic             tx_space_irq,
  output logic             tx_dma_req,
  output logic             rx_ready_irq,
  output logic             rx_dma_req,
  output logic             tx_done_irq,
  output logic             rx_err_irq
);
  ptr_t tx_wfree, tx_rfill, rx_wfree, rx_rfill;
  logic [SP_DW-1:0] rx_head;
  logic [1:0] clr_ser;
  logic tx_clr_s, rx_clr_s;
  logic txc_s, err_s;
  logic [1:0] flags_cpu;
  logic rx_has_data, tx_has_data;

  // clears cross into the shifter domain
  serport_sync #(.W(2)) u_clr_sync (
    .clk(ser_clk), .rst_n(ser_rst_n), .d({tx_clr, rx_clr}), .q(clr_ser)
  );
  assign tx_clr_s = clr_ser[1];
  assign rx_clr_s = clr_ser[0];

  // transmit: processor writes, shifter reads
  serport_dir u_tx (
    .wclk(cpu_clk), .wrst_n(cpu_rst_n), .wclr(tx_clr),
    .rclk(ser_clk), .rrst_n(ser_rst_n), .rclr(tx_clr_s),
    .wide(wide_mode),
    .we(cpu_wr), .wdata(cpu_wdata), .wfree(tx_wfree),
    .re(tx_pop), .rdata(tx_data), .rfill(tx_rfill)
  );

  // receive: shifter writes, processor reads
  serport_dir u_rx (
    .wclk(ser_clk), .wrst_n(ser_rst_n), .wclr(rx_clr_s),
    .rclk(cpu_clk), .rrst_n(cpu_rst_n), .rclr(rx_clr),
    .wide(wide_mode),
    .we(rx_push), .wdata(rx_data), .wfree(rx_wfree),
    .re(cpu_rd), .rdata(rx_head), .rfill(rx_rfill)
  );

  assign tx_has_data = (tx_rfill != '0);
  assign rx_has_data = (rx_rfill != '0);
  assign tx_valid    = tx_has_data;

  // processor read data register
  always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
    if (!cpu_rst_n)                       cpu_rdata <= '0;
    else if (cpu_rd && rx_has_data && !rx_clr) cpu_rdata <= rx_head;
  end

  // threshold flags
  assign tx_space_irq = (tx_wfree >= tx_thr);
  assign tx_dma_req   = tx_space_irq;
  assign rx_ready_irq = (rx_rfill >= rx_thr);
  assign rx_dma_req   = rx_ready_irq;

  // transfer complete, shifter domain
  always_ff @(posedge ser_clk or negedge ser_rst_n) begin
    if (!ser_rst_n)                      txc_s <= 1'b0;
    else if (tx_clr_s || tx_has_data)    txc_s <= 1'b0;
    else if (tx_frame_done)              txc_s <= 1'b1;
  end

  // receive overflow, shifter domain, sticky
  always_ff @(posedge ser_clk or negedge ser_rst_n) begin
    if (!ser_rst_n)                          err_s <= 1'b0;
    else if (rx_clr_s)                       err_s <= 1'b0;
    else if (rx_push && rx_wfree == '0)      err_s <= 1'b1;
  end

  serport_sync #(.W(2)) u_flag_sync (
    .clk(cpu_clk), .rst_n(cpu_rst_n), .d({txc_s, err_s}), .q(flags_cpu)
  );
  assign tx_done_irq = flags_cpu[1];
  assign rx_err_irq  = flags_cpu[0];

  // ---------------- assertions ----------------
  a_r9_rdata_hold: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    (cpu_rd && !rx_has_data) |=> $stable(cpu_rdata));

  a_r5_space_means_room: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    (tx_space_irq && tx_thr != '0) |-> tx_wfree != '0);

  a_r6_ready_means_data: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    (rx_ready_irq && rx_thr != '0) |-> rx_has_data);

  a_r7_done_drops: assert property (@(posedge ser_clk) disable iff (!ser_rst_n)
    tx_has_data |=> !txc_s);

  a_r8_err_set: assert property (@(posedge ser_clk) disable iff (!ser_rst_n)
    (rx_push && rx_wfree == '0 && !rx_clr_s) |=> err_s);

  a_r8_err_sticky: assert property (@(posedge ser_clk) disable iff (!ser_rst_n)
    (err_s && !rx_clr_s) |=> err_s);
endmodule

// File: tb/serport_buf_bench.sv
`timescale 1ns/1ps
module serport_buf_bench;
  logic cpu_clk = 0, ser_clk = 0;
  logic cpu_rst_n = 0, ser_rst_n = 0;
  logic wide_mode = 0;
  logic [4:0] tx_thr = 5'd4, rx_thr = 5'd1;
  logic tx_clr = 0, rx_clr = 0;
  logic cpu_wr = 0, cpu_rd = 0;
  logic [31:0] cpu_wdata = 0, cpu_rdata;
  logic tx_pop = 0, tx_valid;
  logic [31:0] tx_data;
  logic tx_frame_done = 0, rx_push = 0;
  logic [31:0] rx_data = 0;
  logic tx_space_irq, tx_dma_req, rx_ready_irq, rx_dma_req, tx_done_irq, rx_err_irq;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  always #5 cpu_clk = ~cpu_clk;
  always #8 ser_clk = ~ser_clk;

  serport_buf u_serport_buf (
    .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .ser_clk(ser_clk), .ser_rst_n(ser_rst_n),
    .wide_mode(wide_mode), .tx_thr(tx_thr), .rx_thr(rx_thr),
    .tx_clr(tx_clr), .rx_clr(rx_clr),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .tx_pop(tx_pop), .tx_valid(tx_valid), .tx_data(tx_data), .tx_frame_done(tx_frame_done),
    .rx_push(rx_push), .rx_data(rx_data),
    .tx_space_irq(tx_space_irq), .tx_dma_req(tx_dma_req),
    .rx_ready_irq(rx_ready_irq), .rx_dma_req(rx_dma_req),
    .tx_done_irq(tx_done_irq), .rx_err_irq(rx_err_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic settle();
    repeat (5) @(posedge ser_clk);
    repeat (5) @(posedge cpu_clk);
    @(negedge cpu_clk);
  endtask

  task automatic cpu_write(input logic [31:0] d);
    @(negedge cpu_clk); cpu_wr = 1; cpu_wdata = d;
    @(negedge cpu_clk); cpu_wr = 0;
  endtask

  task automatic cpu_read(output logic [31:0] d);
    @(negedge cpu_clk); cpu_rd = 1;
    @(negedge cpu_clk); cpu_rd = 0; d = cpu_rdata;
  endtask

  task automatic ser_pop(output logic v, output logic [31:0] d);
    @(negedge ser_clk); v = tx_valid; d = tx_data; tx_pop = 1;
    @(negedge ser_clk); tx_pop = 0;
  endtask

  task automatic ser_push(input logic [31:0] d);
    @(negedge ser_clk); rx_push = 1; rx_data = d;
    @(negedge ser_clk); rx_push = 0;
  endtask

  task automatic ser_done();
    @(negedge ser_clk); tx_frame_done = 1;
    @(negedge ser_clk); tx_frame_done = 0;
  endtask

  task automatic clear_dir(input bit tx);
    @(negedge cpu_clk);
    if (tx) tx_clr = 1; else rx_clr = 1;
    repeat (6) @(negedge cpu_clk);
    tx_clr = 0; rx_clr = 0;
    settle();
  endtask

  task automatic t_reset();
    settle();
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 rx_ready", rx_ready_irq, 0);
    chk("R1 tx_done", tx_done_irq, 0);
    chk("R1 rx_err", rx_err_irq, 0);
    chk("R1 cpu_rdata", cpu_rdata, 0);
    chk("R1 R5 space at reset", {tx_space_irq, tx_dma_req}, 2'b11);
  endtask

  task automatic t_byte_order();
    logic v; logic [31:0] d;
    cpu_write(32'h1234_56A1); cpu_write(32'hFFFF_FFB2); cpu_write(32'h0000_00C3);
    settle();
    ser_pop(v, d); chk("R2 valid0", v, 1); chk("R2 byte0", d, 32'hA1);
    ser_pop(v, d); chk("R2 byte1", d, 32'hB2);
    ser_pop(v, d); chk("R2 byte2", d, 32'hC3);
    settle();
    chk("R2 drained", tx_valid, 0);
    // pop while empty must not disturb the next entry
    ser_pop(v, d);
    cpu_write(32'h5A); settle();
    ser_pop(v, d); chk("R9 pop on empty ignored", {31'b0, v} ^ 0, 1); chk("R9 next byte", d, 32'h5A);
  endtask

  task automatic t_tx_threshold();
    logic v; logic [31:0] d;
    tx_thr = 5'd4;
    for (int i = 0; i < 12; i++) cpu_write(32'h20 + i);
    settle();
    chk("R5 free4 thr4", {tx_space_irq, tx_dma_req}, 2'b11);
    cpu_write(32'h2C); settle();
    chk("R5 free3 thr4", {tx_space_irq, tx_dma_req}, 2'b00);
    for (int i = 0; i < 13; i++) ser_pop(v, d);
    settle();
    chk("R5 empty again", tx_space_irq, 1);
  endtask

  task automatic t_tx_full();
    logic v; logic [31:0] d;
    for (int i = 0; i < 16; i++) cpu_write(32'h60 + i);
    cpu_write(32'hEE);
    settle();
    tx_thr = 5'd1;
    #1 chk("R5 full no space", tx_space_irq, 0);
    for (int i = 0; i < 16; i++) begin
      ser_pop(v, d);
      chk("R4 kept entry", d, 32'h60 + i);
    end
    settle();
    chk("R4 extra dropped", tx_valid, 0);
    tx_thr = 5'd4;
  endtask

  task automatic t_tx_done();
    logic v; logic [31:0] d;
    ser_done(); settle();
    chk("R7 set when empty", tx_done_irq, 1);
    cpu_write(32'h77); settle();
    chk("R7 cleared by data", tx_done_irq, 0);
    ser_done(); settle();
    chk("R7 no set while data", tx_done_irq, 0);
    ser_pop(v, d); settle();
    chk("R7 no set before done", tx_done_irq, 0);
    ser_done(); settle();
    chk("R7 set after last frame", tx_done_irq, 1);
  endtask

  task automatic t_rx_threshold();
    logic [31:0] d;
    rx_thr = 5'd3;
    ser_push(32'hABCD_EF10); ser_push(32'h20); settle();
    chk("R6 fill2 thr3", {rx_ready_irq, rx_dma_req}, 2'b00);
    ser_push(32'h30); settle();
    chk("R6 fill3 thr3", {rx_ready_irq, rx_dma_req}, 2'b11);
    cpu_read(d); chk("R2 rx byte0", d, 32'h10);
    cpu_read(d); chk("R2 rx byte1", d, 32'h20);
    cpu_read(d); chk("R2 rx byte2", d, 32'h30);
    settle();
    chk("R6 below after reads", rx_ready_irq, 0);
  endtask

  task automatic t_empty_read();
    logic [31:0] d;
    cpu_read(d); chk("R9 hold last", d, 32'h30);
    ser_push(32'h44); settle();
    cpu_read(d); chk("R9 pointer unmoved", d, 32'h44);
  endtask

  task automatic t_rx_overflow_and_clear();
    logic v; logic [31:0] d;
    for (int i = 0; i < 16; i++) ser_push(32'h50 + i);
    settle();
    chk("R8 no err when just full", rx_err_irq, 0);
    ser_push(32'h99); settle();
    chk("R8 err on overflow", rx_err_irq, 1);
    for (int i = 0; i < 16; i++) begin
      cpu_read(d);
      chk("R8 stored intact", d, 32'h50 + i);
    end
    settle();
    chk("R8 sticky", rx_err_irq, 1);
    cpu_write(32'hD1); cpu_write(32'hD2);
    ser_push(32'h88);
    clear_dir(0);
    chk("R10 err cleared", rx_err_irq, 0);
    rx_thr = 5'd1;
    #1 chk("R10 rx empty", rx_ready_irq, 0);
    ser_pop(v, d); chk("R10 tx kept", d, 32'hD1);
    settle();
    chk("R10 tx still has data", tx_valid, 1);
    clear_dir(1);
    chk("R10 tx empty", tx_valid, 0);
    tx_thr = 5'd16;
    #1 chk("R10 R5 free16", tx_space_irq, 1);
  endtask

  task automatic t_wide();
    logic v; logic [31:0] d;
    clear_dir(1); clear_dir(0);
    wide_mode = 1;
    clear_dir(1); clear_dir(0);
    tx_thr = 5'd1;
    for (int i = 0; i < 4; i++) cpu_write(32'hC0DE_0000 + i);
    cpu_write(32'hDEAD_BEEF);
    settle();
    chk("R5 words full", tx_space_irq, 0);
    ser_pop(v, d); chk("R3 word0", d, 32'hC0DE_0000);
    settle();
    chk("R5 one word free", tx_space_irq, 1);
    for (int i = 1; i < 4; i++) begin
      ser_pop(v, d); chk("R3 word order", d, 32'hC0DE_0000 + i);
    end
    settle();
    chk("R4 word dropped", tx_valid, 0);
    rx_thr = 5'd2;
    ser_push(32'h1122_3344); settle();
    chk("R6 one word thr2", rx_ready_irq, 0);
    ser_push(32'h5566_7788); settle();
    chk("R6 two words thr2", rx_ready_irq, 1);
    cpu_read(d); chk("R3 rx word0", d, 32'h1122_3344);
    cpu_read(d); chk("R3 rx word1", d, 32'h5566_7788);
  endtask

  initial begin
    repeat (3) @(negedge cpu_clk);
    cpu_rst_n = 1; ser_rst_n = 1;
    t_reset();
    t_byte_order();
    t_tx_threshold();
    t_tx_full();
    t_tx_done();
    t_rx_threshold();
    t_empty_read();
    t_rx_overflow_and_clear();
    t_wide();
    if (!done_flag) begin
      done_flag = 1;
      summary();
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule